// File: doc/BRIEF.md
# Descriptor Ring Consumer Controller

This block runs the consumer side of a circular ring of 32-byte descriptors kept in memory for an outbound message engine. Software places the address of the first descriptor in a dequeue pointer register and then turns the controller on. While the pointer differs from the enqueue pointer published by the producer, the controller asks for the descriptor at the pointer and waits for a completion pulse. It then moves the pointer on by one descriptor. The move wraps inside a ring region whose size and alignment equal the entry count times 32 bytes.

When the pointer catches up with the enqueue pointer right after a move, the controller halts. It also latches a queue-empty status flag, which drives an interrupt when the interrupt enable is set. The controller stays halted until the producer moves the enqueue pointer. Clearing the enable lets an outstanding descriptor finish and then parks the controller. The pointer can be reloaded only while the controller is parked with the enable low.

The controller has five states, and each move between them is named below.
- IDLE: parked; the only state in which the pointer accepts writes. IDLE goes to CHECK when the enable is high.
- CHECK: evaluates the ring. CHECK goes to FETCH when the pointers differ, to HALT when they are equal, and to IDLE when the enable is low.
- FETCH: the request is held until the completion pulse arrives. FETCH goes to ADVANCE on completion, and the pointer moves at that same edge.
- ADVANCE: compares the moved pointer with the enqueue pointer. It sets the empty flag when they match. ADVANCE goes to IDLE if the enable is low, to HALT if the pointers match, and to FETCH otherwise.
- HALT: waits for the producer. HALT goes to IDLE when the enable is low, and to FETCH when the pointers differ.

Top module: `dring_consumer`

## Requirements
- R1: After reset the pointer reads 0x00000000, the status register reads 0, and fetch_req and irq are 0.
- R2: Address 0 reads the pointer with bits 4:0 always zero. A write to address 0 loads bits 31:5 only while ctl_en is low and the controller is parked. A write made while ctl_en is high leaves the pointer unchanged.
- R3: While enabled and the pointer differs from enq_ptr bits 31:5, fetch_req rises with fetch_addr equal to the pointer. The request and its address then hold steady until fetch_done, so only one request is outstanding.
- R4: A fetch_done pulse during a request moves the pointer forward by 32 bytes within its ring. The entry count is 2^(ring_size_code+1), and codes above 10 are treated as 10. Only the index bits 5 up to 5+code change, so the pointer wraps from the last entry to the ring base.
- R5: If the moved pointer equals enq_ptr, no further request is made, and status bit 0 at address 1 becomes 1 two cycles after the fetch_done cycle.
- R6: A halted controller requests again, one cycle after enq_ptr changes to a value that differs from the pointer.
- R7: irq is high exactly when status bit 0 and empty_irq_en are both high. Writing 1 to bit 0 at address 1 clears the status bit, and writing 0 there leaves it unchanged.
- R8: Dropping ctl_en during a request keeps the request until fetch_done. The pointer still moves, and no new request follows.
- R9: Enabling with the pointer already equal to enq_ptr halts without a request and without setting the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 pointer, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ctl_en | input | 1 | Controller enable |
| ring_size_code | input | 4 | Ring entry count code |
| empty_irq_en | input | 1 | Queue-empty interrupt enable |
| enq_ptr | input | 32 | Producer enqueue pointer |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 32 | Address of the requested descriptor |
| fetch_done | input | 1 | Descriptor processed pulse |
| irq | output | 1 | Queue-empty interrupt |

## Verification
A request appears two cycles after the enable is seen, because it passes through CHECK, and one cycle after enq_ptr moves while halted. The pointer move is visible one cycle after the fetch_done cycle. The empty flag, and any next request, follow one cycle after that. irq and reg_rdata are combinational, so they follow the status bit and the select in the same cycle. The bench drives and samples on the falling edge. It waits exactly these counts, or polls with a bounded wait where only the arrival of the request matters.

// File: rtl/dring_pkg.sv
package dring_pkg;
    localparam int ADDR_W     = 32;
    localparam int DESC_LG2   = 5;
    localparam int SIZE_W     = 4;
    localparam int MAX_CODE   = 10;
    localparam int PTR_W      = ADDR_W - DESC_LG2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_ADVANCE,
        ST_HALT
    } dq_state_e;
endpackage

// File: rtl/dring_ptr.sv
module dring_ptr
    import dring_pkg::*;
#(
    parameter int PW     = PTR_W,
    parameter int SW     = SIZE_W,
    parameter int MAXC   = MAX_CODE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          step,
    input  logic [SW-1:0] size_code,
    output logic [PW-1:0] ptr
);
    localparam int IDX_W = MAXC + 1;

    logic [SW-1:0] code_eff;
    logic [PW-1:0] idx_mask;
    logic [PW-1:0] ptr_inc;
    logic [PW-1:0] ptr_next;

    always_comb begin
        code_eff = (size_code > SW'(MAXC)) ? SW'(MAXC) : size_code;
    end

    generate
        for (genvar g = 0; g < PW; g++) begin : g_mask
            if (g < IDX_W) begin : g_idx
                assign idx_mask[g] = (SW'(g) <= code_eff);
            end else begin : g_hi
                assign idx_mask[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        ptr_inc  = ptr + PW'(1);
        ptr_next = (ptr & ~idx_mask) | (ptr_inc & idx_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr_next;
        end else if (load) begin
            ptr <= load_val;
        end
    end
endmodule

// File: rtl/dring_status.sv
module dring_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_flag,
    input  logic clr_flag,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
    import dring_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      ptr_eq,
    input  logic      done,
    output dq_state_e state,
    output logic      req,
    output logic      step,
    output logic      set_empty,
    output logic      parked
);
    dq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (en) state_nx = ST_CHECK;
            ST_CHECK:   if (!en)        state_nx = ST_IDLE;
                        else if (ptr_eq) state_nx = ST_HALT;
                        else             state_nx = ST_FETCH;
            ST_FETCH:   if (done) state_nx = ST_ADVANCE;
            ST_ADVANCE: if (!en)        state_nx = ST_IDLE;
                        else if (ptr_eq) state_nx = ST_HALT;
                        else             state_nx = ST_FETCH;
            ST_HALT:    if (!en)        state_nx = ST_IDLE;
                        else if (!ptr_eq) state_nx = ST_FETCH;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        req       = 1'b0;
        step      = 1'b0;
        set_empty = 1'b0;
        parked    = 1'b0;
        unique case (state)
            ST_IDLE:    parked = 1'b1;
            ST_CHECK:   ;
            ST_FETCH:   begin
                req  = 1'b1;
                step = done;
            end
            ST_ADVANCE: set_empty = ptr_eq;
            ST_HALT:    ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dring_consumer.sv
module dring_consumer
    import dring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              ctl_en,
    input  logic [SIZE_W-1:0] ring_size_code,
    input  logic              empty_irq_en,
    input  logic [ADDR_W-1:0] enq_ptr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_done,
    output logic              irq
);
    dq_state_e         state;
    logic [PTR_W-1:0]  ptr_q;
    logic              ptr_eq;
    logic              step;
    logic              set_empty;
    logic              parked;
    logic              empty_q;
    logic              ptr_load;
    logic              empty_clr;

    assign ptr_eq    = (ptr_q == enq_ptr[ADDR_W-1:DESC_LG2]);
    assign ptr_load  = reg_wr && !reg_addr && parked && !ctl_en;
    assign empty_clr = reg_wr && reg_addr && reg_wdata[0];

    dring_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .ptr_eq    (ptr_eq),
        .done      (fetch_done),
        .state     (state),
        .req       (fetch_req),
        .step      (step),
        .set_empty (set_empty),
        .parked    (parked)
    );

    dring_ptr #(
        .PW   (PTR_W),
        .SW   (SIZE_W),
        .MAXC (MAX_CODE)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_val  (reg_wdata[ADDR_W-1:DESC_LG2]),
        .step      (step),
        .size_code (ring_size_code),
        .ptr       (ptr_q)
    );

    dring_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_flag (set_empty),
        .clr_flag (empty_clr),
        .flag     (empty_q)
    );

    assign fetch_addr = {ptr_q, {DESC_LG2{1'b0}}};
    assign reg_rdata  = reg_addr ? {{(ADDR_W-1){1'b0}}, empty_q}
                                 : {ptr_q, {DESC_LG2{1'b0}}};
    assign irq        = empty_q && empty_irq_en;
endmodule

// File: rtl/dring_consumer_chk.sv
module dring_consumer_chk
    import dring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             empty_irq_en,
    input  logic             fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic             fetch_done,
    input  logic             irq,
    input  logic             empty_q,
    input  logic [PTR_W-1:0] ptr_q
);
    // R3: a pending request stays up with a steady address until completion
    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_done) |=> (fetch_req && $stable(fetch_addr)));

    // R4: a completion always moves the pointer (rings have at least two entries)
    assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_done) |=> (ptr_q != $past(ptr_q)));

    // R2: while enabled, the pointer changes only by a completed descriptor
    assert_ptr_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && !$past(fetch_req && fetch_done)) |-> $stable(ptr_q));

    // R5: the cycle the empty flag rises, no request is pending
    assert_empty_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_q) |-> !fetch_req);

    // R7: the interrupt needs the enable and the flag
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (empty_irq_en && empty_q));

    // R8: disabled with nothing pending, no new request starts
    assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !fetch_req) |=> !fetch_req);
endmodule

bind dring_consumer dring_consumer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en       (ctl_en),
    .empty_irq_en (empty_irq_en),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .fetch_done   (fetch_done),
    .irq          (irq),
    .empty_q      (empty_q),
    .ptr_q        (ptr_q)
);

// File: tb/dring_consumer_tb.sv
module dring_consumer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_en = 1'b0;
    logic [3:0]  ring_size_code = 4'd2;
    logic        empty_irq_en = 1'b0;
    logic [31:0] enq_ptr = '0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dring_consumer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_en(ctl_en),
        .ring_size_code(ring_size_code), .empty_irq_en(empty_irq_en),
        .enq_ptr(enq_ptr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_done(fetch_done), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic [31:0] start;
        logic [31:0] enq;
        logic [31:0] nxt;
        logic        empty;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  32'h0000_1000, 32'h0000_1040, 32'h0000_1020, 1'b0},
        '{4'd2,  32'h0000_10E0, 32'h0000_1000, 32'h0000_1000, 1'b1},
        '{4'd0,  32'h0000_2020, 32'h0000_2000, 32'h0000_2000, 1'b1},
        '{4'd10, 32'h3000_FFE0, 32'h3000_0020, 32'h3000_0000, 1'b0},
        '{4'd15, 32'h4000_FFE0, 32'h4000_0000, 32'h4000_0000, 1'b1},
        '{4'd0,  32'h0000_5000, 32'h0000_5020, 32'h0000_5020, 1'b1}
    };

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 10; i++) begin
            if (fetch_req) break;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(2);
        // R1: reset values
        rd(1'b0, v); check("R1 ptr", v, 32'h0);
        rd(1'b1, v); check("R1 status", v, 32'h0);
        check("R1 req", {31'b0, fetch_req}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        step();

        // R2: low bits read as zero
        wr(1'b0, 32'h0000_123F);
        rd(1'b0, v); check("R2 low bits", v, 32'h0000_1220);

        // R9: enable with empty ring -> halt, no request, no flag
        enq_ptr = 32'h0000_1220; ring_size_code = 4'd2; ctl_en = 1'b1;
        step(3);
        check("R9 no req", {31'b0, fetch_req}, 32'h0);
        rd(1'b1, v); check("R9 no flag", v, 32'h0);

        // R2: write while enabled ignored
        wr(1'b0, 32'h0000_5000);
        rd(1'b0, v); check("R2 write ignored", v, 32'h0000_1220);

        // R6: producer bump releases halt one cycle later
        enq_ptr = 32'h0000_1240;
        step();
        check("R6 req", {31'b0, fetch_req}, 32'h1);
        check("R3 addr", fetch_addr, 32'h0000_1220);
        step(3);
        check("R3 req held", {31'b0, fetch_req}, 32'h1);
        check("R3 addr held", fetch_addr, 32'h0000_1220);

        // R5: completion empties the ring
        fetch_done = 1'b1; step(); fetch_done = 1'b0;
        step();
        rd(1'b1, v); check("R5 flag", v, 32'h1);
        rd(1'b0, v); check("R4 ptr", v, 32'h0000_1240);
        check("R5 no req", {31'b0, fetch_req}, 32'h0);

        // R7: interrupt gating and write-1-to-clear
        empty_irq_en = 1'b0; #0.5;
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        empty_irq_en = 1'b1; #0.5;
        check("R7 irq on", {31'b0, irq}, 32'h1);
        wr(1'b1, 32'h0);
        rd(1'b1, v); check("R7 w0 keeps", v, 32'h1);
        wr(1'b1, 32'h1);
        rd(1'b1, v); check("R7 w1 clears", v, 32'h0);
        check("R7 irq off", {31'b0, irq}, 32'h0);

        // R8: disable during a request
        enq_ptr = 32'h0000_1280;
        step();
        check("R6 req again", {31'b0, fetch_req}, 32'h1);
        ctl_en = 1'b0;
        step(2);
        check("R8 req kept", {31'b0, fetch_req}, 32'h1);
        fetch_done = 1'b1; step(); fetch_done = 1'b0;
        step(2);
        check("R8 no new req", {31'b0, fetch_req}, 32'h0);
        rd(1'b0, v); check("R8 ptr moved", v, 32'h0000_1260);

        // vector table: R3/R4/R5 across ring sizes and wraps
        for (int k = 0; k < NV; k++) begin
            wr(1'b1, 32'h1);
            wr(1'b0, VEC[k].start);
            ring_size_code = VEC[k].code;
            enq_ptr = VEC[k].enq;
            ctl_en = 1'b1;
            step();
            wait_req();
            check("R3 vec req", {31'b0, fetch_req}, 32'h1);
            check("R3 vec addr", fetch_addr, VEC[k].start);
            fetch_done = 1'b1; ctl_en = 1'b0;
            step();
            fetch_done = 1'b0;
            step(3);
            rd(1'b0, v); check("R4 vec next", v, VEC[k].nxt);
            rd(1'b1, v); check("R5 vec flag", v, {31'b0, VEC[k].empty});
            check("R7 vec irq", {31'b0, irq}, {31'b0, VEC[k].empty});
            check("R8 vec idle", {31'b0, fetch_req}, 32'h0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule